// File: doc/BRIEF.md
# Single-Word SDRAM Command Sequencer

This block sits between a host and one SDRAM device. The host raises a request for a single word, either a read or a write, and holds it until the block acknowledges. The block turns each request into an activate command followed by a column command. The column command sets the auto-precharge bit, so the row closes by itself. Reads return their word on a one-cycle response strobe once the CAS latency has passed. After reset the block waits for the power-up time. It then precharges every bank, issues two auto-refresh commands and programs the mode register. Once that sequence is done it serves host requests. It also inserts an auto-refresh command at a fixed interval.

All spacings between commands are parameters given in clock counts, with defaults sized for a 100 MHz clock. One down-counter sets the time until the next command may leave. Only one request is handled at a time, and every row is closed again before the next request is accepted. Any cycle without a command carries the no-operation code.

Top module: `sdram_cmd_seq`

## Requirements
- R1: The command pins {cs_n, ras_n, cas_n, we_n} take only these codes: 0000 mode set, 0001 auto-refresh, 0010 precharge, 0011 activate, 0100 write, 0101 read, 0111 no-operation. Chip select stays low.
- R2: After reset, at least INIT_WAIT cycles pass before any command. The first four commands are then, in order: precharge with sd_addr[10]=1 (all banks), auto-refresh, auto-refresh, and mode set with sd_addr=12'h020 (burst length 1, sequential, CAS latency 2). No host access happens before the mode set.
- R3: req_addr is {bank, row, column}, most significant field first. Activate carries the bank on sd_ba and the row on sd_addr. The read or write that follows uses the same bank and puts the column on sd_addr[9:0] with sd_addr[10]=1. It comes at least T_RCD cycles after the activate.
- R4: Two activate commands are at least T_RC cycles apart.
- R5: After an auto-refresh, the next command waits at least T_RFC cycles. After a mode set it waits at least T_MRD cycles, and after a precharge at least T_RP cycles.
- R6: A read returns its word on rsp_rdata with rsp_valid high for one cycle. This happens CAS_LAT+1 cycles after the read command cycle. The word is the one sampled from sd_dq_i at the CAS latency.
- R7: sd_dq_oe is high only in the cycle of a write command, and sd_dq_o then carries that request's write data.
- R8: Auto-refresh is issued at least once every REF_INTERVAL cycles, plus a short slack for the access in flight. When a refresh is due and a host request is waiting, the refresh is issued first.
- R9: req_ack is a one-cycle pulse, given once for each accepted request.
- R10: During reset the pins carry no-operation, and sd_dq_oe, req_ack and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BANK_W+ROW_W+COL_W | {bank, row, column} |
| req_wdata | input | DATA_W | Write word |
| req_ack | output | 1 | Request accepted (pulse) |
| rsp_valid | output | 1 | Read word valid (pulse) |
| rsp_rdata | output | DATA_W | Read word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_addr | output | ROW_W | Row, column or mode word |
| sd_dq_o | output | DATA_W | Write data to the device |
| sd_dq_oe | output | 1 | Write data drive enable |
| sd_dq_i | input | DATA_W | Read data from the device |

## Verification
The refresh timer can fall due in the same cycle that a host request waits for the idle state, and the two then compete for the command bus. The bench provokes this with a long run of back-to-back requests that spans several refresh intervals, so refreshes come due while req_valid is held. The bench judges the outcome in four ways. At least one refresh must appear while a request is still waiting. No two refreshes may be further apart than the interval plus the slack. The activate that follows a refresh must respect the refresh recovery time. Every read in the run must still return the word last written.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // Pin code {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_IREF1,
    ST_IREF2,
    ST_IMRS,
    ST_IDLE,
    ST_COL
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
  parameter int W         = 8,
  parameter int RESET_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= W'(RESET_VAL);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic served,
  output logic due
);
  localparam int CW = $clog2(INTERVAL);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      due <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + CW'(1);
      due <= wrap | (due & ~served);
    end
  end
endmodule

// File: rtl/sdram_read_pipe.sv
module sdram_read_pipe #(
  parameter int LAT = 2,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [DW-1:0] dq_i,
  output logic          vld,
  output logic [DW-1:0] data
);
  logic [LAT:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      vld  <= 1'b0;
      data <= '0;
    end else begin
      sr  <= {sr[LAT-1:0], launch};
      vld <= sr[LAT];
      if (sr[LAT]) data <= dq_i;
    end
  end
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 10,
  parameter int DATA_W       = 8,
  parameter int INIT_WAIT    = 20000,
  parameter int REF_INTERVAL = 1560,
  parameter int T_RCD        = 2,
  parameter int T_RAS        = 5,
  parameter int T_RC         = 7,
  parameter int T_RP         = 2,
  parameter int T_MRD        = 2,
  parameter int T_RFC        = 7,
  parameter int T_DAL        = 3,
  parameter int CAS_LAT      = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]               req_wdata,
  output logic                            req_ack,
  output logic                            rsp_valid,
  output logic [DATA_W-1:0]               rsp_rdata,
  output logic                            sd_cs_n,
  output logic                            sd_ras_n,
  output logic                            sd_cas_n,
  output logic                            sd_we_n,
  output logic [BANK_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]                sd_addr,
  output logic [DATA_W-1:0]               sd_dq_o,
  output logic                            sd_dq_oe,
  input  logic [DATA_W-1:0]               sd_dq_i
);
  import sdram_seq_pkg::*;

  localparam int AW       = BANK_W + ROW_W + COL_W;
  // Wait after the column command until the next activate may leave
  localparam int COL_GAP  = imax(imax(T_RC - T_RCD, T_RAS - T_RCD + T_RP),
                                 imax(T_DAL, CAS_LAT + 1));
  localparam int WAIT_MAX = imax(imax(INIT_WAIT, T_RFC), imax(COL_GAP, T_RCD));
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam logic [ROW_W-1:0] AP_BIT    = ROW_W'(1) << 10;
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'({3'(CAS_LAT), 1'b0, 3'b000});

  seq_state_e          state, nxt_state;
  sd_cmd_e             cmd_q, nxt_cmd;
  logic [BANK_W-1:0]   ba_q, nxt_ba;
  logic [ROW_W-1:0]    addr_q, nxt_addr;
  logic                wait_ld, wait_zero;
  logic [WAIT_W-1:0]   wait_val;
  logic                ref_due, ref_served, take_req, launch_rd;
  logic                lat_write;
  logic [COL_W-1:0]    lat_col;
  logic [DATA_W-1:0]   lat_wdata;

  sdram_wait_timer #(.W(WAIT_W), .RESET_VAL(INIT_WAIT)) u_wait (
    .clk(clk), .rst(rst), .load(wait_ld), .load_val(wait_val), .zero(wait_zero)
  );

  sdram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst(rst), .served(ref_served), .due(ref_due)
  );

  sdram_read_pipe #(.LAT(CAS_LAT), .DW(DATA_W)) u_rdp (
    .clk(clk), .rst(rst), .launch(launch_rd), .dq_i(sd_dq_i),
    .vld(rsp_valid), .data(rsp_rdata)
  );

  always_comb begin
    nxt_state  = state;
    nxt_cmd    = CMD_NOP;
    nxt_ba     = ba_q;
    nxt_addr   = addr_q;
    wait_ld    = 1'b0;
    wait_val   = '0;
    take_req   = 1'b0;
    ref_served = 1'b0;
    launch_rd  = 1'b0;
    if (wait_zero) begin
      unique case (state)
        ST_PWR: begin
          nxt_cmd = CMD_PRE; nxt_addr = AP_BIT;
          wait_ld = 1'b1; wait_val = WAIT_W'(T_RP - 1); nxt_state = ST_IREF1;
        end
        ST_IREF1: begin
          nxt_cmd = CMD_REF;
          wait_ld = 1'b1; wait_val = WAIT_W'(T_RFC - 1); nxt_state = ST_IREF2;
        end
        ST_IREF2: begin
          nxt_cmd = CMD_REF;
          wait_ld = 1'b1; wait_val = WAIT_W'(T_RFC - 1); nxt_state = ST_IMRS;
        end
        ST_IMRS: begin
          nxt_cmd = CMD_MRS; nxt_addr = MODE_WORD;
          wait_ld = 1'b1; wait_val = WAIT_W'(T_MRD - 1); nxt_state = ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_due) begin
            nxt_cmd = CMD_REF; ref_served = 1'b1;
            wait_ld = 1'b1; wait_val = WAIT_W'(T_RFC - 1);
          end else if (req_valid) begin
            nxt_cmd  = CMD_ACT; take_req = 1'b1;
            nxt_ba   = req_addr[AW-1 -: BANK_W];
            nxt_addr = req_addr[COL_W +: ROW_W];
            wait_ld  = 1'b1; wait_val = WAIT_W'(T_RCD - 1); nxt_state = ST_COL;
          end
        end
        ST_COL: begin
          nxt_cmd   = lat_write ? CMD_WR : CMD_RD;
          launch_rd = ~lat_write;
          nxt_addr  = ROW_W'(lat_col) | AP_BIT;
          wait_ld   = 1'b1; wait_val = WAIT_W'(COL_GAP - 1); nxt_state = ST_IDLE;
        end
        default: nxt_state = ST_PWR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_PWR;
      cmd_q     <= CMD_NOP;
      ba_q      <= '0;
      addr_q    <= '0;
      sd_dq_o   <= '0;
      sd_dq_oe  <= 1'b0;
      req_ack   <= 1'b0;
      lat_write <= 1'b0;
      lat_col   <= '0;
      lat_wdata <= '0;
    end else begin
      state    <= nxt_state;
      cmd_q    <= nxt_cmd;
      ba_q     <= nxt_ba;
      addr_q   <= nxt_addr;
      req_ack  <= take_req;
      sd_dq_oe <= (nxt_cmd == CMD_WR);
      if (nxt_cmd == CMD_WR) sd_dq_o <= lat_wdata;
      if (take_req) begin
        lat_write <= req_write;
        lat_col   <= req_addr[COL_W-1:0];
        lat_wdata <= req_wdata;
      end
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba   = ba_q;
  assign sd_addr = addr_q;
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk #(
  parameter int ROW_W = 12,
  parameter int T_RCD = 2,
  parameter int T_RC  = 7,
  parameter int T_RFC = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [ROW_W-1:0] sd_addr,
  input logic             sd_dq_oe,
  input logic             req_ack,
  input logic             rsp_valid
);
  import sdram_seq_pkg::*;

  logic [3:0] cmd;
  logic [7:0] act_gap, ref_gap;

  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      act_gap <= '1;
      ref_gap <= '1;
    end else begin
      if (cmd == CMD_ACT)      act_gap <= 8'd1;
      else if (act_gap != '1)  act_gap <= act_gap + 8'd1;
      if (cmd == CMD_REF)      ref_gap <= 8'd1;
      else if (ref_gap != '1)  ref_gap <= ref_gap + 8'd1;
    end
  end

  // R1
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    cmd inside {CMD_MRS, CMD_REF, CMD_PRE, CMD_ACT, CMD_WR, CMD_RD, CMD_NOP});

  // R3
  col_autoprecharge_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_RD || cmd == CMD_WR) |-> sd_addr[10]);

  generate
    if (T_RCD > 1) begin : g_rcd
      // R3
      act_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACT) |=> (cmd == CMD_NOP));
    end
  endgenerate

  // R4
  act_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_ACT) |-> (act_gap >= 8'(T_RC)));

  // R5
  refresh_recovery_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_NOP) |-> (ref_gap >= 8'(T_RFC)));

  // R7
  drive_only_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    sd_dq_oe |-> (cmd == CMD_WR));

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
  .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RC(T_RC), .T_RFC(T_RFC)
) u_chk (
  .clk(clk), .rst(rst), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
  .sd_dq_oe(sd_dq_oe), .req_ack(req_ack), .rsp_valid(rsp_valid)
);

// File: tb/sdram_cmd_seq_test.sv
module sdram_cmd_seq_test;
  localparam int BW = 2, RW = 12, CW = 10, DW = 8, AW = 24;
  localparam int CL = 2, RCD = 2, RC = 7, RFC = 7, RP = 2, MRD = 2;
  localparam int INITW = 12, REFI = 120, REF_SLACK = 16;
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                         C_NOP = 4'b0111;

  logic          clk = 1'b0, rst = 1'b1;
  logic          req_valid, req_write, req_ack, rsp_valid;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rsp_rdata, sd_dq_o, sd_dq_i;
  logic          sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [BW-1:0] sd_ba;
  logic [RW-1:0] sd_addr;

  always #10 clk = ~clk;

  sdram_cmd_seq #(.INIT_WAIT(INITW), .REF_INTERVAL(REFI)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_o(sd_dq_o),
    .sd_dq_oe(sd_dq_oe), .sd_dq_i(sd_dq_i)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  // Device model and pin-level timing checks (sampled mid-cycle)
  logic [DW-1:0] mem [logic [AW-1:0]];
  logic [DW-1:0] shadow [logic [AW-1:0]];
  logic [RW-1:0] open_row [4];
  logic [DW-1:0] exp_q [$];
  int            rd_cyc_q [$];
  int cyc = 0, ncmd = 0, rd_cd = 0, ref_busy = 0, n_reqs = 0, n_acks = 0, n_rsp = 0;
  int last_act = -1000, last_ref = -1000, last_mrs = -1000, last_pre = -1000;
  int act_bank = 0;
  bit init_done = 1'b0;
  logic [DW-1:0] rd_word;

  always @(negedge clk) begin
    logic [3:0]    c;
    logic [AW-1:0] key;
    if (!rst) begin
      cyc++;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (sd_dq_oe && c != C_WR) check(1'b0, "R7 drive outside write", c, C_WR);
      if (req_ack) n_acks++;
      if (rd_cd != 0) begin
        rd_cd--;
        if (rd_cd == 0) sd_dq_i = rd_word;
      end
      if (c != C_NOP) begin
        check(c inside {C_MRS, C_REF, C_PRE, C_ACT, C_WR, C_RD}, "R1 legal code", c, C_NOP);
        if (ncmd > 0) begin
          check(cyc - last_ref >= RFC, "R5 refresh recovery", cyc - last_ref, RFC);
          check(cyc - last_mrs >= MRD, "R5 mode set recovery", cyc - last_mrs, MRD);
          check(cyc - last_pre >= RP, "R5 precharge recovery", cyc - last_pre, RP);
        end
        case (ncmd)
          0: begin
            check(c == C_PRE && sd_addr[10], "R2 first is precharge-all", c, C_PRE);
            check(cyc >= INITW, "R2 power-up wait", cyc, INITW);
          end
          1, 2: check(c == C_REF, "R2 init refresh", c, C_REF);
          3: begin
            check(c == C_MRS, "R2 mode set", c, C_MRS);
            check(sd_addr == 12'h020, "R2 mode word", sd_addr, 12'h020);
          end
          default: ;
        endcase
        case (c)
          C_ACT: begin
            check(cyc - last_act >= RC, "R4 activate spacing", cyc - last_act, RC);
            open_row[sd_ba] = sd_addr;
            act_bank = sd_ba;
            last_act = cyc;
          end
          C_RD, C_WR: begin
            check(sd_addr[10], "R3 auto-precharge bit", sd_addr[10], 1);
            check(cyc - last_act >= RCD, "R3 activate to column", cyc - last_act, RCD);
            check(sd_ba == act_bank, "R3 column bank", sd_ba, act_bank);
            key = {sd_ba, open_row[sd_ba], sd_addr[CW-1:0]};
            if (c == C_WR) begin
              check(sd_dq_oe, "R7 drive on write", sd_dq_oe, 1);
              mem[key] = sd_dq_o;
            end else begin
              rd_word = mem.exists(key) ? mem[key] : '0;
              rd_cd = CL;
              rd_cyc_q.push_back(cyc);
            end
          end
          C_REF: begin
            if (init_done)
              check(cyc - last_ref <= REFI + REF_SLACK, "R8 refresh interval", cyc - last_ref, REFI + REF_SLACK);
            if (req_valid) ref_busy++;
            last_ref = cyc;
          end
          C_MRS: begin last_mrs = cyc; init_done = 1'b1; end
          C_PRE: last_pre = cyc;
          default: ;
        endcase
        ncmd++;
      end else if (!init_done && ncmd == 0 && req_valid) begin
        check(1'b0, "R2 access before init", 1, 0);
      end
      // Scoreboard monitor
      if (rsp_valid) begin
        n_rsp++;
        if (exp_q.size() == 0) check(1'b0, "R6 unexpected response", 1, 0);
        else check(rsp_rdata == exp_q[0], "R6 read data", rsp_rdata, exp_q[0]);
        if (exp_q.size() != 0) void'(exp_q.pop_front());
        if (rd_cyc_q.size() != 0) begin
          check(cyc - rd_cyc_q[0] == CL + 1, "R6 read latency", cyc - rd_cyc_q[0], CL + 1);
          void'(rd_cyc_q.pop_front());
        end
      end
    end
  end

  // Driver: one request, expected read data pushed to the scoreboard
  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) shadow[a] = d;
    else exp_q.push_back(shadow.exists(a) ? shadow[a] : '0);
    n_reqs++;
    do @(negedge clk); while (!req_ack);
    req_valid = 1'b0;
    @(negedge clk);
    check(!req_ack, "R9 acknowledge is one pulse", req_ack, 0);
  endtask

  initial begin
    logic [AW-1:0] a;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; sd_dq_i = '0;
    repeat (3) @(negedge clk);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R10 reset command", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    check(!sd_dq_oe && !req_ack && !rsp_valid, "R10 reset strobes", {sd_dq_oe, req_ack, rsp_valid}, 0);
    rst = 1'b0;
    while (!init_done) @(negedge clk);
    // Directed patterns
    issue(1'b1, {2'd0, 12'd5, 10'd3}, 8'hA5);
    issue(1'b0, {2'd0, 12'd5, 10'd3}, '0);
    issue(1'b1, {2'd3, 12'hFFF, 10'h3FF}, 8'h3C);
    issue(1'b0, {2'd3, 12'hFFF, 10'h3FF}, '0);
    issue(1'b1, {2'd0, 12'd6, 10'd3}, 8'h77);
    issue(1'b0, {2'd0, 12'd5, 10'd3}, '0);
    issue(1'b1, {2'd0, 12'd5, 10'd3}, 8'h11);
    issue(1'b0, {2'd0, 12'd5, 10'd3}, '0);
    issue(1'b0, {2'd2, 12'd9, 10'd9}, '0);
    // Back-to-back traffic across several refresh intervals
    for (int i = 0; i < 80; i++) begin
      a = {2'(i % 4), 12'((i * 37) % 4096), 10'((i * 13) % 1024)};
      issue(1'b1, a, 8'(i * 7 + 1));
      issue(1'b0, a, '0);
    end
    // Idle: refresh must continue alone
    repeat (400) @(negedge clk);
    check(exp_q.size() == 0, "R6 all reads answered", exp_q.size(), 0);
    check(n_rsp > 0, "R6 responses seen", n_rsp, 1);
    check(ref_busy >= 1, "R8 refresh ahead of waiting request", ref_busy, 1);
    check(n_acks == n_reqs, "R9 one acknowledge per request", n_acks, n_reqs);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_reqs, 169);
      finish_run();
    end
  end
endmodule